// File: doc/BRIEF.md
# Prescaled Register Watchdog Timer

This block is a core watchdog timer with a memory-mapped programming model: one 64-bit control word and one poke address. A fixed prescaler divides the bus clock so that the 24-bit countdown moves by one step only every 2^PRE_SHIFT cycles. With the default PRE_SHIFT of 10, that is once every 1024 cycles. The control word holds a mode, a 16-bit reload length and a 24-bit live count.

The reload length only sets the upper 16 bits of the counter, so every reload puts `{length, 8'h00}` into the counter. Any write to the poke address reloads the counter this way, whatever data is written. In the armed mode, the counter reaching zero raises a reset-request output. That output stays high until software writes the control word again. Writing zero to the control word turns the watchdog off.

Software starts the watchdog with one control write that sets the mode, the length and, if it wants, a first count. It then writes the poke address from time to time so the count never runs out. It can read the control word back to see how far the live count has dropped.

Top module: `wdg_core_watchdog`

## Requirements
- R1: After reset, `reset_req` is 0 and a read of the control address returns 0.
- R2: The control word layout is: mode in bits [1:0], length in bits [19:4], count in bits [43:20]. A read of the control address returns the mode, the length and the live count in those same positions, and returns 0 in every other bit. Read data appears on `bus_rdata` one cycle after the cycle in which `bus_rd` is high.
- R3: A control write whose count field is nonzero loads that value straight into the counter. A control write whose count field is zero loads `{length, 8'h00}`.
- R4: While the mode is nonzero, the counter drops by exactly one every 1024 clock cycles. The prescaler phase restarts at every control write and every poke. The counter never goes below zero.
- R5: Any write to the poke address (the control address + 0x10000) reloads the counter with `{length, 8'h00}`, whatever the write data is. A read of the poke address returns 0.
- R6: In mode 3, `reset_req` goes to 1 on the clock edge at which the counter reaches zero. For a loaded count N, that edge is 1024·N cycles after the load.
- R7: Once `reset_req` is 1, it stays 1 through pokes and through further counting. It returns to 0 only on a control write.
- R8: In mode 0, the counter and the prescaler are held at zero, pokes have no effect, and `reset_req` stays 0. Writing all zeros to the control word selects mode 0.
- R9: In modes 1 and 2, the counter counts down and stops at zero, but `reset_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 20 | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| reset_req | output | 1 | Sticky reset request raised on expiry in mode 3 |

## Verification
The assertions check four things on every cycle:
- `reset_req` can only rise in mode 3, and only with the counter at zero.
- `reset_req` stays high until a control write, and a control write clears it.
- The counter is zero throughout mode 0.
- Without a write, the counter either holds or drops by exactly one.

Three behaviours can only be shown by the bench scenarios:
- The exact 1024-cycle step, and the expiry edge at 1024·N cycles.
- The choice between loading the written count and loading the shifted length.
- The restart of the prescaler phase at a poke, which keeps an armed watchdog from expiring.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int WORD_W  = 64;
    localparam int MODE_LO = 0;
    localparam int MODE_W  = 2;
    localparam int LEN_LO  = 4;
    localparam int LEN_W   = 16;
    localparam int CNT_LO  = 20;
    localparam int CNT_W   = 24;
    localparam int FILL_W  = CNT_W - LEN_W;

    typedef enum logic [MODE_W-1:0] {
        WDM_OFF   = 2'd0,
        WDM_RUN_A = 2'd1,
        WDM_RUN_B = 2'd2,
        WDM_ARMED = 2'd3
    } wdg_mode_e;

    typedef struct packed {
        wdg_mode_e          mode;
        logic [LEN_W-1:0]   len;
        logic [CNT_W-1:0]   cnt;
    } wdg_ctrl_t;

    function automatic wdg_ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        wdg_ctrl_t c;
        c.mode = wdg_mode_e'(w[MODE_LO +: MODE_W]);
        c.len  = w[LEN_LO +: LEN_W];
        c.cnt  = w[CNT_LO +: CNT_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(input wdg_ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_LO +: MODE_W] = c.mode;
        w[LEN_LO +: LEN_W]   = c.len;
        w[CNT_LO +: CNT_W]   = c.cnt;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] reload_value(input logic [LEN_W-1:0] len);
        return {len, {FILL_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wdg_regif.sv
module wdg_regif
    import wdg_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] POKE_OFF  = 20'h10000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [CNT_W-1:0]    live_cnt,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                ctrl_wr,
    output logic                poke_wr,
    output wdg_ctrl_t           wr_fields,
    output wdg_mode_e           mode_q,
    output logic [LEN_W-1:0]    len_q
);

    localparam logic [ADDR_W-1:0] POKE_ADDR = CTRL_ADDR + POKE_OFF;

    logic hit_ctrl;
    logic hit_poke;
    wdg_ctrl_t rd_view;

    always_comb begin
        hit_ctrl  = (bus_addr == CTRL_ADDR);
        hit_poke  = (bus_addr == POKE_ADDR);
        ctrl_wr   = bus_wr && hit_ctrl;
        poke_wr   = bus_wr && hit_poke;
        wr_fields = ctrl_unpack(bus_wdata);
        rd_view.mode = mode_q;
        rd_view.len  = len_q;
        rd_view.cnt  = live_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WDM_OFF;
            len_q  <= '0;
        end else if (ctrl_wr) begin
            mode_q <= wr_fields.mode;
            len_q  <= wr_fields.len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd && hit_ctrl) begin
            bus_rdata <= ctrl_pack(rd_view);
        end else begin
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int PRE_SHIFT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);

    localparam int PW = (PRE_SHIFT < 1) ? 1 : PRE_SHIFT;

    generate
        if (PRE_SHIFT == 0) begin : g_nodiv
            assign tick = !clear;
        end else begin : g_div
            logic [PW-1:0] phase;
            always_ff @(posedge clk) begin
                if (rst || clear) phase <= '0;
                else              phase <= phase + 1'b1;
            end
            assign tick = !clear && (&phase);
        end
    endgenerate

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ctrl_wr,
    input  logic              poke_wr,
    input  wdg_ctrl_t         wr_fields,
    input  wdg_mode_e         mode_q,
    input  logic [LEN_W-1:0]  len_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              expire_q
);

    logic [CNT_W-1:0] load_val;
    logic             at_end;

    always_comb begin
        if (wr_fields.mode == WDM_OFF)  load_val = '0;
        else if (wr_fields.cnt != '0)   load_val = wr_fields.cnt;
        else                            load_val = reload_value(wr_fields.len);
        at_end = (cnt_q <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_wr) begin
            cnt_q <= load_val;
        end else if (mode_q == WDM_OFF) begin
            cnt_q <= '0;
        end else if (poke_wr) begin
            cnt_q <= reload_value(len_q);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            expire_q <= 1'b0;
        end else if (tick && mode_q == WDM_ARMED && !poke_wr && at_end) begin
            expire_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdg_core_watchdog.sv
module wdg_core_watchdog
    import wdg_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] POKE_OFF  = 20'h10000,
    parameter int          PRE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              reset_req
);

    logic             ctrl_wr;
    logic             poke_wr;
    wdg_ctrl_t        wr_fields;
    wdg_mode_e        mode_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             pre_clear;

    assign pre_clear = ctrl_wr || poke_wr || (mode_q == WDM_OFF);

    wdg_regif #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .POKE_OFF(POKE_OFF)
    ) u_regif (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_cnt(cnt_q),
        .bus_rdata(bus_rdata), .ctrl_wr(ctrl_wr), .poke_wr(poke_wr),
        .wr_fields(wr_fields), .mode_q(mode_q), .len_q(len_q)
    );

    wdg_prescale #(.PRE_SHIFT(PRE_SHIFT)) u_pre (
        .clk(clk), .rst(rst), .clear(pre_clear), .tick(tick)
    );

    wdg_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(ctrl_wr),
        .poke_wr(poke_wr), .wr_fields(wr_fields), .mode_q(mode_q),
        .len_q(len_q), .cnt_q(cnt_q), .expire_q(reset_req)
    );

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             ctrl_wr,
    input logic             reset_req,
    input wdg_mode_e        mode_q,
    input logic [CNT_W-1:0] cnt_q
);

    // R6 / R9: a new request only appears in mode 3 with the counter at zero
    assert_rise_armed_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |-> (mode_q == WDM_ARMED && cnt_q == '0));

    // R7: the request holds until a control write
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (reset_req && !ctrl_wr) |=> reset_req);

    // R7: a control write clears the request
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !reset_req);

    // R8: mode 0 keeps the counter at zero and never requests reset
    assert_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WDM_OFF) |-> (cnt_q == '0 && !reset_req));

    // R4: without a write the counter holds or drops by exactly one
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && mode_q != WDM_OFF) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

endmodule

bind wdg_core_watchdog wdg_checker u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .ctrl_wr(ctrl_wr),
    .reset_req(reset_req), .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/tb_wdg_core_watchdog.sv
module tb_wdg_core_watchdog;

    localparam logic [19:0] CTRL = 20'h00000;
    localparam logic [19:0] POKE = 20'h10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        reset_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    wdg_core_watchdog dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    function automatic logic [63:0] word(input logic [1:0] m,
                                         input logic [15:0] l,
                                         input logic [23:0] c);
        logic [63:0] w;
        w = '0;
        w[1:0] = m; w[19:4] = l; w[43:20] = c;
        return w;
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [19:0] a, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [19:0] a, input logic [63:0] exp,
                           input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 reset_req after reset", {63'b0, reset_req}, 64'd0);
        do_read(CTRL, 64'd0, "R1 control read after reset");

        // R2 / R3 direct count load, field readback
        do_write(CTRL, word(2'd1, 16'hABCD, 24'h000005));
        do_read(CTRL, word(2'd1, 16'hABCD, 24'h000005), "R2 R3 readback of fields");
        // bits outside fields read zero
        do_write(CTRL, 64'hFFFF_F000_0000_000D | word(2'd1, 16'h0001, 24'h000005));
        do_read(CTRL, word(2'd1, 16'h0001, 24'h000005), "R2 unused bits read zero");

        // R4 one step per 1024 cycles (write edge E0, read sampled at E1101)
        do_write(CTRL, word(2'd1, 16'h0000, 24'h000005));
        wait_cyc(1100);
        do_read(CTRL, word(2'd1, 16'h0000, 24'h000004), "R4 first step after 1024");
        wait_cyc(1024 - 2);
        do_read(CTRL, word(2'd1, 16'h0000, 24'h000003), "R4 second step");

        // R3 zero count field loads {len,8'h00}
        do_write(CTRL, word(2'd3, 16'h0002, 24'h000000));
        do_read(CTRL, word(2'd3, 16'h0002, 24'h000200), "R3 shifted length load");

        // R5 poke reloads, poke read returns zero
        do_write(CTRL, word(2'd1, 16'h0001, 24'h000003));
        do_write(POKE, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(CTRL, word(2'd1, 16'h0001, 24'h000100), "R5 poke all ones reload");
        do_write(CTRL, word(2'd1, 16'h0001, 24'h000003));
        do_write(POKE, 64'h0);
        do_read(CTRL, word(2'd1, 16'h0001, 24'h000100), "R5 poke zero data reload");
        do_read(POKE, 64'd0, "R5 poke address reads zero");

        // R6 expiry edge at 1024*N
        do_write(CTRL, word(2'd3, 16'h0000, 24'h000002));
        wait_cyc(2047);
        check("R6 no request before 2048", {63'b0, reset_req}, 64'd0);
        wait_cyc(1);
        check("R6 request at 2048", {63'b0, reset_req}, 64'd1);

        // R7 sticky through poke and counting
        do_write(POKE, 64'h1);
        wait_cyc(1500);
        check("R7 request held after poke", {63'b0, reset_req}, 64'd1);
        do_write(CTRL, word(2'd3, 16'h0001, 24'h000000));
        check("R7 cleared by control write", {63'b0, reset_req}, 64'd0);

        // R5 / R4 poke restarts phase and prevents expiry
        do_write(CTRL, word(2'd3, 16'h0001, 24'h000002));
        wait_cyc(2000);
        do_write(POKE, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_cyc(1000);
        check("R5 no expiry after timely poke", {63'b0, reset_req}, 64'd0);
        do_read(CTRL, word(2'd3, 16'h0001, 24'h000100), "R4 poke restarts prescaler");

        // R8 mode 0 holds everything
        do_write(CTRL, 64'd0);
        do_read(CTRL, 64'd0, "R8 disable reads zero");
        do_write(CTRL, word(2'd0, 16'h0005, 24'h000007));
        do_write(POKE, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_cyc(3000);
        do_read(CTRL, word(2'd0, 16'h0005, 24'h000000), "R8 mode 0 count held at zero");
        check("R8 no request in mode 0", {63'b0, reset_req}, 64'd0);

        // R9 modes 1 and 2 stop at zero, no request
        do_write(CTRL, word(2'd2, 16'h0000, 24'h000002));
        wait_cyc(3500);
        check("R9 mode 2 no request", {63'b0, reset_req}, 64'd0);
        do_read(CTRL, word(2'd2, 16'h0000, 24'h000000), "R9 mode 2 stops at zero");
        do_write(CTRL, word(2'd1, 16'h0000, 24'h000001));
        wait_cyc(2500);
        check("R9 mode 1 no request", {63'b0, reset_req}, 64'd0);
        do_read(CTRL, word(2'd1, 16'h0000, 24'h000000), "R9 mode 1 stops at zero");

        wait_cyc(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule